// File: doc/BRIEF.md
# Two-Machine Buffered Line Supervisor

This block supervises part flow on a small production line. An upstream machine passes finished parts into a one-slot buffer, and a downstream machine takes its parts from that buffer. Each machine can be idle, working or down. The supervisor watches the plant one event per clock: a valid strobe and a three-bit event code. It tracks the combined state of both machines and the buffer, and it decides which controllable events the plant may issue next.

Starts and repairs are controllable, so the block gates them through a four-bit enable vector. Finishes and breakdowns are uncontrollable. The supervisor only observes them to advance its state and never masks them. The enable vector is built from the product of the two machine models and a one-slot buffer rule. As a result, the upstream machine can never be commanded to start while the slot is full, and the downstream machine can never be commanded to start while the slot is empty.

The block also has two flags. A marker flag reports when the line is back in its home state, with both machines idle and the buffer empty. A sticky error flag records any event the supervisor refused.

Top module: `cell_supervisor`

## Requirements
- R1: A synchronous reset puts the line in its home state: state 0, enable vector 4'b0001 and error low.
- R2: The state output is {upstream[1:0], slot, downstream[1:0]}. A machine field is 0 for idle, 1 for working and 2 for down. The slot bit is 1 when the buffer holds a part. The event code is {machine, kind}, where machine 0 is upstream and kind is 0 start, 1 finish, 2 breakdown, 3 repair.
- R3: Start moves a machine from idle to working. Finish moves it from working to idle. Breakdown moves it from working to down. Repair moves it from down to idle.
- R4: An accepted upstream finish fills the slot, and an accepted downstream start empties it.
- R5: In the enable vector, bit 0 allows the upstream start and is set only when upstream is idle and the slot is empty. Bit 2 allows the downstream start and is set only when downstream is idle and the slot is full. Bit 1 allows the upstream repair and bit 3 allows the downstream repair; each is set only when its machine is down.
- R6: The enable vector is registered. It shows the state that held one cycle earlier.
- R7: A start or repair is accepted only if its enable bit is high in the same cycle. Otherwise the error flag is raised and the state is unchanged. This covers a start into a full slot and a start from an empty slot.
- R8: An event that is not defined in the current machine state raises the error flag and leaves the state unchanged.
- R9: A finish or breakdown is accepted whenever it is defined, whatever the enable vector holds.
- R10: The error flag stays high until reset, and accepted events still advance the state while it is high.
- R11: The marker output is high exactly when the state is 0.
- R12: When the valid strobe is low, the state and the error flag do not change.
- R13: The slot is full only while the upstream machine is idle, so no more than 12 composite states are reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | An observed event is present this cycle |
| ev_code | input | 3 | Event code {machine, kind} |
| state_o | output | 5 | Composite line state |
| enable_o | output | 4 | Enables for the controllable events |
| marker_o | output | 1 | Line is in its home state |
| error_o | output | 1 | Sticky flag for a refused event |

## Verification
The bench tries an upstream start while the slot is full and a downstream start while the slot is empty. A design that let either through would report a state with two parts in the line, or a part that was never made. One test sends a downstream start and an upstream start back to back, so the second start arrives while the enable vector still shows the older state. A design that checked its gate against the new state instead of the registered enable would accept that second start. Other tests send finishes with every enable low, which exposes a design that gates uncontrollable events. Further tests send out-of-state events, which catch a design that changes state instead of raising the flag, and check that the error flag stays set after later legal events.

// File: rtl/cell_sup_pkg.sv
package cell_sup_pkg;

   localparam int NUM_MACH = 2;
   localparam int KIND_W   = 2;
   localparam int MSEL_W   = 1;
   localparam int CODE_W   = MSEL_W + KIND_W;
   localparam int MST_W    = 2;
   localparam int STATE_W  = NUM_MACH * MST_W + 1;
   localparam int EN_W     = 2 * NUM_MACH;

   typedef enum logic [MST_W-1:0] {
      MS_IDLE = 2'd0,
      MS_WORK = 2'd1,
      MS_DOWN = 2'd2
   } mach_st_t;

   typedef enum logic [KIND_W-1:0] {
      EK_START  = 2'd0,
      EK_FINISH = 2'd1,
      EK_BREAK  = 2'd2,
      EK_REPAIR = 2'd3
   } ev_kind_t;

endpackage

// File: rtl/cell_machine.sv
module cell_machine
   import cell_sup_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     fire,
   input  ev_kind_t kind,
   output logic     legal,
   output mach_st_t st
);

   mach_st_t st_nx;

   always_comb begin
      legal = 1'b0;
      st_nx = st;
      unique case (kind)
         EK_START: begin
            legal = (st == MS_IDLE);
            st_nx = MS_WORK;
         end
         EK_FINISH: begin
            legal = (st == MS_WORK);
            st_nx = MS_IDLE;
         end
         EK_BREAK: begin
            legal = (st == MS_WORK);
            st_nx = MS_DOWN;
         end
         default: begin
            legal = (st == MS_DOWN);
            st_nx = MS_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         st <= MS_IDLE;
      else if (fire)
         st <= st_nx;
   end

   AST_REPAIR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
      (fire && kind == EK_REPAIR) |=> (st == MS_IDLE)); // R3

   AST_NO_FIRE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !fire |=> $stable(st)); // R8

endmodule

// File: rtl/cell_slot.sv
module cell_slot #(
   parameter int CAP = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic fill,
   input  logic drain,
   output logic full
);

   generate
      if (CAP == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst)
               full <= 1'b0;
            else if (fill)
               full <= 1'b1;
            else if (drain)
               full <= 1'b0;
         end
      end else begin : g_bad_cap
         $error("cell_slot: only a one-part slot is supported");
         assign full = 1'b0;
      end
   endgenerate

   AST_FILL_DRAIN_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(fill && drain)); // R4

   AST_FILL_SETS: assert property (@(posedge clk) disable iff (rst)
      fill |=> full); // R4

endmodule

// File: rtl/cell_enable.sv
module cell_enable
   import cell_sup_pkg::*;
(
   input  logic                clk,
   input  logic                rst,
   input  mach_st_t            mst [NUM_MACH],
   input  logic                full,
   output logic [EN_W-1:0]     en
);

   localparam logic [EN_W-1:0] HOME_EN = EN_W'(1);

   logic [EN_W-1:0] en_nx;

   generate
      for (genvar i = 0; i < NUM_MACH; i++) begin : g_en
         logic slot_ok;
         if (i == 0) begin : g_up
            assign slot_ok = !full;
         end else begin : g_dn
            assign slot_ok = full;
         end
         assign en_nx[2*i]   = (mst[i] == MS_IDLE) && slot_ok;
         assign en_nx[2*i+1] = (mst[i] == MS_DOWN);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         en <= HOME_EN;
      else
         en <= en_nx;
   end

endmodule

// File: rtl/cell_supervisor.sv
module cell_supervisor
   import cell_sup_pkg::*;
#(
   parameter int SLOT_CAP = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ev_valid,
   input  logic [CODE_W-1:0]   ev_code,
   output logic [STATE_W-1:0]  state_o,
   output logic [EN_W-1:0]     enable_o,
   output logic                marker_o,
   output logic                error_o
);

   logic [MSEL_W-1:0] sel;
   ev_kind_t          kind;
   mach_st_t          mst   [NUM_MACH];
   logic [NUM_MACH-1:0] legal;
   logic [NUM_MACH-1:0] fire;
   logic              full;
   logic              slot_ok;
   logic              is_ctrl;
   logic              gate_ok;
   logic              accept;
   logic              fill;
   logic              drain;

   assign sel  = ev_code[CODE_W-1 -: MSEL_W];
   assign kind = ev_kind_t'(ev_code[KIND_W-1:0]);

   generate
      for (genvar i = 0; i < NUM_MACH; i++) begin : g_mach
         assign fire[i] = accept && (sel == MSEL_W'(i));
         cell_machine u_mach (
            .clk   (clk),
            .rst   (rst),
            .fire  (fire[i]),
            .kind  (kind),
            .legal (legal[i]),
            .st    (mst[i])
         );
      end
   endgenerate

   cell_slot #(.CAP(SLOT_CAP)) u_slot (
      .clk   (clk),
      .rst   (rst),
      .fill  (fill),
      .drain (drain),
      .full  (full)
   );

   cell_enable u_en (
      .clk  (clk),
      .rst  (rst),
      .mst  (mst),
      .full (full),
      .en   (enable_o)
   );

   // slot rule: upstream finish needs room, downstream start needs a part
   always_comb begin
      slot_ok = 1'b1;
      if (sel == '0 && kind == EK_FINISH && full)
         slot_ok = 1'b0;
      if (sel != '0 && kind == EK_START && !full)
         slot_ok = 1'b0;
   end

   assign is_ctrl = (kind == EK_START) || (kind == EK_REPAIR);
   assign gate_ok = !is_ctrl || enable_o[{sel, kind == EK_REPAIR}];
   assign accept  = ev_valid && legal[sel] && slot_ok && gate_ok;
   assign fill    = accept && (sel == '0) && (kind == EK_FINISH);
   assign drain   = accept && (sel != '0) && (kind == EK_START);

   always_ff @(posedge clk) begin
      if (rst)
         error_o <= 1'b0;
      else if (ev_valid && !accept)
         error_o <= 1'b1;
   end

   assign state_o  = {mst[0], full, mst[1]};
   assign marker_o = (state_o == '0);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (ev_valid && ev_code == 3'd0 && state_o[2]) |=> (error_o && $stable(state_o))); // R7

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      (ev_valid && ev_code == 3'd4 && !state_o[2]) |=> (error_o && $stable(state_o))); // R7

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      error_o |=> error_o); // R10

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !ev_valid |=> ($stable(state_o) && $stable(error_o))); // R12

   AST_FULL_UP_IDLE: assert property (@(posedge clk) disable iff (rst)
      state_o[2] |-> (state_o[4:3] == 2'd0)); // R13

   AST_UNCTRL_PASS: assert property (@(posedge clk) disable iff (rst)
      (ev_valid && ev_code == 3'd5 && state_o[1:0] == 2'd1) |=> (state_o[1:0] == 2'd0)); // R9

endmodule

// File: tb/sim_cell_supervisor.sv
`timescale 1ns/1ps
module sim_cell_supervisor;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ev_valid = 1'b0;
   logic [2:0] ev_code = 3'd0;
   logic [4:0] state_o;
   logic [3:0] enable_o;
   logic       marker_o;
   logic       error_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   cell_supervisor u0 (
      .clk      (clk),
      .rst      (rst),
      .ev_valid (ev_valid),
      .ev_code  (ev_code),
      .state_o  (state_o),
      .enable_o (enable_o),
      .marker_o (marker_o),
      .error_o  (error_o)
   );

   // vector = {event code[11:9], expected state[8:4], expected enable[3:0]}
   // all steps are legal; marker expected high iff state is 0, error stays 0
   localparam int NV = 16;
   localparam logic [11:0] VEC [NV] = '{
      {3'd0, 5'b01000, 4'b0000},  // up start          R3
      {3'd1, 5'b00100, 4'b0100},  // up finish, fills  R4 R9
      {3'd4, 5'b00001, 4'b0001},  // dn start, drains  R4
      {3'd0, 5'b01001, 4'b0000},  // up start
      {3'd6, 5'b01010, 4'b1000},  // dn breakdown      R3 R9
      {3'd2, 5'b10010, 4'b1010},  // up breakdown
      {3'd3, 5'b00010, 4'b1001},  // up repair         R5
      {3'd7, 5'b00000, 4'b0001},  // dn repair         R11
      {3'd0, 5'b01000, 4'b0000},
      {3'd1, 5'b00100, 4'b0100},
      {3'd4, 5'b00001, 4'b0001},
      {3'd0, 5'b01001, 4'b0000},
      {3'd1, 5'b00101, 4'b0000},  // full slot, dn working
      {3'd5, 5'b00100, 4'b0100},  // dn finish, all gates low R9
      {3'd4, 5'b00001, 4'b0001},
      {3'd5, 5'b00000, 4'b0001}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive one event; check state/error one edge later, enable one more edge later
   task automatic step(input logic [2:0] code, input logic [4:0] es,
                       input logic [3:0] een, input logic eerr, input string req);
      ev_valid = 1'b1;
      ev_code  = code;
      @(negedge clk);
      ev_valid = 1'b0;
      chk({req, " state"}, 32'(state_o), 32'(es));
      chk({req, " error"}, 32'(error_o), 32'(eerr));
      chk("R11 marker", 32'(marker_o), 32'(es == 5'd0));
      @(negedge clk);
      chk("R6 enable", 32'(enable_o), 32'(een));
   endtask

   task automatic do_reset();
      rst = 1'b1;
      ev_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 state", 32'(state_o), 32'd0);
      chk("R1 enable", 32'(enable_o), 32'b0001);
      chk("R1 error", 32'(error_o), 32'd0);
      chk("R11 marker", 32'(marker_o), 32'd1);

      // table walk: R2 R3 R4 R5 R6 R9
      for (int i = 0; i < NV; i++)
         step(VEC[i][11:9], VEC[i][8:4], VEC[i][3:0], 1'b0, "R3 table");

      // R12: codes without valid strobe have no effect
      ev_code = 3'd4;
      repeat (3) @(negedge clk);
      chk("R12 state", 32'(state_o), 32'd0);
      chk("R12 error", 32'(error_o), 32'd0);
      ev_code = 3'd0;

      // R8: finish while idle
      step(3'd1, 5'b00000, 4'b0001, 1'b1, "R8 finish idle");
      do_reset();
      // R8: breakdown while idle
      step(3'd6, 5'b00000, 4'b0001, 1'b1, "R8 break idle");
      do_reset();
      // R7 underflow: downstream start with empty slot
      step(3'd4, 5'b00000, 4'b0001, 1'b1, "R7 underflow");
      do_reset();
      // R7: repair while not down (gate low)
      step(3'd3, 5'b00000, 4'b0001, 1'b1, "R7 repair gate");
      do_reset();

      // R7 overflow: upstream start with full slot
      step(3'd0, 5'b01000, 4'b0000, 1'b0, "R4 fill prep");
      step(3'd1, 5'b00100, 4'b0100, 1'b0, "R4 fill prep");
      step(3'd0, 5'b00100, 4'b0100, 1'b1, "R7 overflow");
      // R10: legal events still advance with error set, flag remains
      step(3'd4, 5'b00001, 4'b0001, 1'b1, "R10 sticky");
      step(3'd0, 5'b01001, 4'b0000, 1'b1, "R10 sticky");
      do_reset();
      // R1: reset clears after activity
      chk("R1 state after", 32'(state_o), 32'd0);
      chk("R1 error after", 32'(error_o), 32'd0);
      chk("R1 enable after", 32'(enable_o), 32'b0001);

      // R6/R7: back-to-back starts, second sees the stale enable and is refused
      step(3'd0, 5'b01000, 4'b0000, 1'b0, "R6 prep");
      step(3'd1, 5'b00100, 4'b0100, 1'b0, "R6 prep");
      ev_valid = 1'b1;
      ev_code  = 3'd4;
      @(negedge clk);
      chk("R4 drain b2b", 32'(state_o), 32'b00001);
      ev_code  = 3'd0;
      @(negedge clk);
      ev_valid = 1'b0;
      chk("R6 stale gate state", 32'(state_o), 32'b00001);
      chk("R6 stale gate error", 32'(error_o), 32'd1);
      @(negedge clk);
      chk("R5 enable after drain", 32'(enable_o), 32'b0001);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule